// File: doc/BRIEF.md
# Configurable Logic Cluster with Local Crossbar

This block is one tile of programmable logic. Ten splittable logic elements share a clock and are fed by a full local crossbar. Each element has six inputs and two outputs. It works either as one 6-input lookup table or as two 5-input lookup tables that share the lower five inputs. Each of its two outputs can be taken straight from the table or from a flip-flop that captures the table's value. Each of the sixty element inputs picks its source on its own. The source can be any of the 33 cluster inputs or any of the twenty element flip-flops, which gives registered local feedback. A source can also be a constant zero.

The whole setup is held in one serial configuration image and is loaded through a scan chain. Crossbar selects come first in the image, then the ten element words. The chain shifts one bit per clock while `cfg_shift` is high. The bit shifted in first ends up at image bit 0. Cluster outputs are wired at fixed places: the low ten carry each element's first output and the high ten carry each element's second output.

Top module: `logic_cluster`

## Requirements
- R1: Select codes 0 to 32 route cluster input `clu_in[code]` to the element input. The select for input i of element e sits at image bits [(e*6+i)*6 +: 6].
- R2: Select codes 33 to 42 route the first-output flip-flop of element code-33. Codes 43 to 52 route the second-output flip-flop of element code-43.
- R3: Select codes 53 to 63 drive a constant 0 into the element input.
- R4: In split mode (mode bit 0), output 0 is mask[{0,in[4:0]}] and output 1 is mask[{1,in[4:0]}]. Each element word starts at image bit 360+e*67: mask at [63:0], mode at [64], output-0 register select at [65], output-1 register select at [66].
- R5: In whole mode (mode bit 1), output 0 is mask[in[5:0]] and output 1 is 0.
- R6: When an output's register select is 1, that output shows the table value captured at the previous clock. The flip-flops are the feedback sources of R2.
- R7: `clu_out[e]` carries output 0 of element e and `clu_out[10+e]` carries output 1 of element e.
- R8: While `cfg_shift` is high the image moves one place toward bit 0 each clock, with `cfg_in` entering at the top. `cfg_out` always shows image bit 0 and does not change while `cfg_shift` is low.
- R9: Element flip-flops hold their values while `cfg_shift` is high.
- R10: Reset (`rst_n` low) clears the image and all flip-flops, so every cluster output reads 0 and `cfg_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock, shared by all elements and the chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shift | input | 1 | Shift the configuration chain one place this clock |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (image bit 0) |
| clu_in | input | 33 | Cluster inputs |
| clu_out | output | 20 | Cluster outputs, grouped by element output index |

## Verification
The bench builds the cluster at its default size: 33 inputs, ten elements of six inputs, and a 1030-bit chain. With these values every one of the 64 select codes can be reached, including all eleven zero codes. Both element modes, both register settings and feedback from every flip-flop are exercised. Reloading an unchanged image at full length shows the old image leaving through `cfg_out` bit for bit, while the held flip-flops keep the outputs steady.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic {
        LUT_SPLIT = 1'b0,
        LUT_WHOLE = 1'b1
    } lut_mode_e;

    localparam int DEF_CL_IN   = 33;
    localparam int DEF_N_ELEM  = 10;
    localparam int DEF_ELEM_IN = 6;

endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] image,
    output logic         ser_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            image <= '0;
        end else if (shift_en) begin
            image <= {ser_in, image[W-1:1]};
        end
    end

    assign ser_out = image[0];

endmodule

// File: rtl/lc_xbar.sv
module lc_xbar #(
    parameter int N_SRC  = 53,
    parameter int N_SINK = 60,
    parameter int SEL_W  = 6
) (
    input  logic [N_SRC-1:0]        src,
    input  logic [N_SINK*SEL_W-1:0] sel,
    output logic [N_SINK-1:0]       sink
);

    localparam int N_CODE = 2 ** SEL_W;

    logic [N_CODE-1:0] src_pad;
    assign src_pad = {{(N_CODE - N_SRC){1'b0}}, src};

    for (genvar g = 0; g < N_SINK; g++) begin : g_pin
        logic [SEL_W-1:0] code;
        assign code    = sel[g*SEL_W +: SEL_W];
        assign sink[g] = src_pad[code];
    end

endmodule

// File: rtl/lc_fle.sv
module lc_fle
    import lc_pkg::*;
#(
    parameter int K = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [K-1:0]    fin,
    input  logic [2**K-1:0] mask,
    input  lut_mode_e       mode,
    input  logic            reg0,
    input  logic            reg1,
    output logic [1:0]      fout,
    output logic [1:0]      q
);

    logic lut0;
    logic lut1;

    always_comb begin
        unique case (mode)
            LUT_WHOLE: begin
                lut0 = mask[fin];
                lut1 = 1'b0;
            end
            LUT_SPLIT: begin
                lut0 = mask[{1'b0, fin[K-2:0]}];
                lut1 = mask[{1'b1, fin[K-2:0]}];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 2'b00;
        end else if (!hold) begin
            q <= {lut1, lut0};
        end
    end

    assign fout[0] = reg0 ? q[0] : lut0;
    assign fout[1] = reg1 ? q[1] : lut1;

endmodule

// File: rtl/logic_cluster.sv
module logic_cluster
    import lc_pkg::*;
#(
    parameter int CL_IN   = DEF_CL_IN,
    parameter int N_ELEM  = DEF_N_ELEM,
    parameter int ELEM_IN = DEF_ELEM_IN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_shift,
    input  logic                  cfg_in,
    output logic                  cfg_out,
    input  logic [CL_IN-1:0]      clu_in,
    output logic [2*N_ELEM-1:0]   clu_out
);

    localparam int N_OUT      = 2 * N_ELEM;
    localparam int N_SRC      = CL_IN + N_OUT;
    localparam int SEL_W      = $clog2(N_SRC + 1);
    localparam int N_PIN      = N_ELEM * ELEM_IN;
    localparam int XBAR_W     = N_PIN * SEL_W;
    localparam int LUT_BITS   = 2 ** ELEM_IN;
    localparam int ELEM_CFG_W = LUT_BITS + 3;
    localparam int CFG_W      = XBAR_W + N_ELEM * ELEM_CFG_W;

    logic [CFG_W-1:0]  cfg_image;
    logic [N_PIN-1:0]  pin;
    logic [N_OUT-1:0]  fb;
    logic [N_ELEM-1:0] q0_vec;
    logic [N_ELEM-1:0] q1_vec;
    logic [N_ELEM-1:0] elem_out0;
    logic [N_ELEM-1:0] elem_out1;
    logic [N_ELEM-1:0] elem_whole;

    lc_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .ser_in   (cfg_in),
        .image    (cfg_image),
        .ser_out  (cfg_out)
    );

    assign fb = {q1_vec, q0_vec};

    lc_xbar #(.N_SRC(N_SRC), .N_SINK(N_PIN), .SEL_W(SEL_W)) u_xbar (
        .src  ({fb, clu_in}),
        .sel  (cfg_image[XBAR_W-1:0]),
        .sink (pin)
    );

    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        localparam int BASE = XBAR_W + e * ELEM_CFG_W;
        logic [1:0] fo;
        logic [1:0] fq;

        assign elem_whole[e] = cfg_image[BASE + LUT_BITS];

        lc_fle #(.K(ELEM_IN)) u_fle (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (cfg_shift),
            .fin   (pin[e*ELEM_IN +: ELEM_IN]),
            .mask  (cfg_image[BASE +: LUT_BITS]),
            .mode  (lut_mode_e'(elem_whole[e])),
            .reg0  (cfg_image[BASE + LUT_BITS + 1]),
            .reg1  (cfg_image[BASE + LUT_BITS + 2]),
            .fout  (fo),
            .q     (fq)
        );

        assign elem_out0[e] = fo[0];
        assign elem_out1[e] = fo[1];
        assign q0_vec[e]    = fq[0];
        assign q1_vec[e]    = fq[1];
    end

    assign clu_out = {elem_out1, elem_out0};

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
    parameter int N_ELEM = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_shift,
    input logic                cfg_out,
    input logic [2*N_ELEM-1:0] clu_out,
    input logic [N_ELEM-1:0]   q0,
    input logic [N_ELEM-1:0]   q1,
    input logic [N_ELEM-1:0]   whole,
    input logic [N_ELEM-1:0]   out1
);

    // R10: first cycle out of reset shows an all-zero cluster output
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clu_out == '0));

    // R9: element flip-flops keep their state across a shift clock
    a_r9_hold_ff: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> $stable({q1, q0}));

    // R8: serial output stays put when the chain is idle
    a_r8_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(cfg_out));

    // R5: a whole-mode element never raises its second output once settled
    a_r5_whole_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift && $past(!cfg_shift)) |-> ((whole & out1) == '0));

endmodule

bind logic_cluster lc_checker #(.N_ELEM(N_ELEM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_out   (cfg_out),
    .clu_out   (clu_out),
    .q0        (q0_vec),
    .q1        (q1_vec),
    .whole     (elem_whole),
    .out1      (elem_out1)
);

// File: tb/logic_cluster_tb.sv
module logic_cluster_tb;

    localparam int CL_IN  = 33;
    localparam int N_ELEM = 10;
    localparam int N_OUT  = 20;
    localparam int XBAR_W = 360;
    localparam int ECW    = 67;
    localparam int CFG_W  = XBAR_W + N_ELEM * ECW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_shift = 1'b0;
    logic             cfg_in = 1'b0;
    logic [CL_IN-1:0] clu_in = '0;
    logic             cfg_out;
    logic [N_OUT-1:0] clu_out;

    always #5 clk = ~clk;

    logic_cluster u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_shift (cfg_shift),
        .cfg_in    (cfg_in),
        .cfg_out   (cfg_out),
        .clu_in    (clu_in),
        .clu_out   (clu_out)
    );

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    int          sel_m [N_ELEM][6];
    logic [63:0] mask_m [N_ELEM];
    bit          whole_m [N_ELEM];
    bit          rg0_m [N_ELEM];
    bit          rg1_m [N_ELEM];
    bit          q0_m [N_ELEM];
    bit          q1_m [N_ELEM];
    bit          nx0 [N_ELEM];
    bit          nx1 [N_ELEM];
    logic [CFG_W-1:0] loaded = '0;

    task automatic check(string tag, logic [N_OUT-1:0] got, logic [N_OUT-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [CFG_W-1:0] build_image();
        logic [CFG_W-1:0] img = '0;
        for (int e = 0; e < N_ELEM; e++) begin
            for (int i = 0; i < 6; i++) begin
                img[(e*6+i)*6 +: 6] = sel_m[e][i][5:0];
            end
            img[XBAR_W + e*ECW +: 64] = mask_m[e];
            img[XBAR_W + e*ECW + 64]  = whole_m[e];
            img[XBAR_W + e*ECW + 65]  = rg0_m[e];
            img[XBAR_W + e*ECW + 66]  = rg1_m[e];
        end
        return img;
    endfunction

    function automatic bit src_bit(int s, logic [CL_IN-1:0] v);
        if (s < 33) return v[s];
        if (s < 43) return q0_m[s-33];
        if (s < 53) return q1_m[s-43];
        return 1'b0;
    endfunction

    function automatic logic [N_OUT-1:0] model_eval(logic [CL_IN-1:0] v);
        logic [N_OUT-1:0] o = '0;
        for (int e = 0; e < N_ELEM; e++) begin
            logic [5:0] a;
            bit l0, l1;
            for (int i = 0; i < 6; i++) a[i] = src_bit(sel_m[e][i], v);
            if (whole_m[e]) begin
                l0 = mask_m[e][a];
                l1 = 1'b0;
            end else begin
                l0 = mask_m[e][{1'b0, a[4:0]}];
                l1 = mask_m[e][{1'b1, a[4:0]}];
            end
            nx0[e]    = l0;
            nx1[e]    = l1;
            o[e]      = rg0_m[e] ? q0_m[e] : l0;
            o[10 + e] = rg1_m[e] ? q1_m[e] : l1;
        end
        return o;
    endfunction

    task automatic run_cycle(string tag, logic [CL_IN-1:0] v);
        logic [N_OUT-1:0] exp;
        clu_in = v;
        @(negedge clk);
        exp = model_eval(v);
        check(tag, clu_out, exp);
        @(posedge clk);
        #1;
        for (int e = 0; e < N_ELEM; e++) begin
            q0_m[e] = nx0[e];
            q1_m[e] = nx1[e];
        end
    endtask

    task automatic run_random(string tag, int n);
        for (int c = 0; c < n; c++) begin
            logic [63:0] r = {$urandom(), $urandom()};
            run_cycle(tag, r[CL_IN-1:0]);
        end
    endtask

    // R8: image leaves through cfg_out bit 0 first while the new one enters
    task automatic shift_image(string tag);
        logic [CFG_W-1:0] img = build_image();
        for (int k = 0; k < CFG_W; k++) begin
            cfg_in    = img[k];
            cfg_shift = 1'b1;
            @(negedge clk);
            check(tag, {19'd0, cfg_out}, {19'd0, loaded[k]});
            @(posedge clk);
            #1;
        end
        cfg_shift = 1'b0;
        cfg_in    = 1'b0;
        loaded    = img;
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        cfg_shift = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n  = 1'b1;
        loaded = '0;
        for (int e = 0; e < N_ELEM; e++) begin
            q0_m[e] = 1'b0;
            q1_m[e] = 1'b0;
            for (int i = 0; i < 6; i++) sel_m[e][i] = 0;
            mask_m[e]  = '0;
            whole_m[e] = 1'b0;
            rg0_m[e]   = 1'b0;
            rg1_m[e]   = 1'b0;
        end
    endtask

    task automatic check_reset_state();
        for (int c = 0; c < 4; c++) begin
            logic [63:0] r = {$urandom(), $urandom()};
            clu_in = r[CL_IN-1:0];
            @(negedge clk);
            check("R10 outputs", clu_out, '0);
            check("R10 cfg_out", {19'd0, cfg_out}, '0);
            @(posedge clk);
            #1;
        end
    endtask

    task automatic random_masks();
        for (int e = 0; e < N_ELEM; e++) mask_m[e] = {$urandom(), $urandom()};
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check_reset_state();

        // R1 R7 R4: cluster inputs only, split mode, direct outputs
        random_masks();
        for (int e = 0; e < N_ELEM; e++)
            for (int i = 0; i < 6; i++) sel_m[e][i] = (e*6 + i) % 33;
        shift_image("R8 first load");
        run_random("R1 R4 R7 input routing", 40);

        // R3: every zero code, split and whole mixed
        for (int e = 0; e < N_ELEM; e++) begin
            whole_m[e] = e[0];
            for (int i = 0; i < 6; i++) sel_m[e][i] = 53 + (e*6 + i) % 11;
        end
        random_masks();
        shift_image("R8 second load");
        run_random("R3 zero codes", 20);

        // R2 R6: registered outputs with feedback from every flip-flop
        for (int e = 0; e < N_ELEM; e++) begin
            whole_m[e] = 1'b0;
            rg0_m[e]   = 1'b1;
            rg1_m[e]   = 1'b1;
            for (int i = 0; i < 6; i++)
                sel_m[e][i] = (i < 3) ? 33 + (e*3 + i) % 20 : (e + i*5) % 33;
        end
        random_masks();
        shift_image("R8 third load");
        run_random("R2 R6 feedback", 60);

        // R5: whole mode, mixed register selects, any codes
        for (int e = 0; e < N_ELEM; e++) begin
            whole_m[e] = 1'b1;
            rg0_m[e]   = e[0];
            rg1_m[e]   = e[1];
            for (int i = 0; i < 6; i++) sel_m[e][i] = $urandom_range(63, 0);
        end
        random_masks();
        shift_image("R8 fourth load");
        run_random("R5 whole mode", 60);

        // R9 R8: reload the same image; flip-flops must not move meanwhile
        shift_image("R8 reload passthrough");
        run_random("R9 hold across reload", 20);

        // all features mixed
        for (int t = 0; t < 3; t++) begin
            for (int e = 0; e < N_ELEM; e++) begin
                whole_m[e] = bit'($urandom_range(1, 0));
                rg0_m[e]   = bit'($urandom_range(1, 0));
                rg1_m[e]   = bit'($urandom_range(1, 0));
                for (int i = 0; i < 6; i++) sel_m[e][i] = $urandom_range(63, 0);
            end
            random_masks();
            shift_image("R8 mixed load");
            run_random("R1 R2 R3 R4 R5 R6 R7 mixed", 80);
        end

        // R10: reset after a loaded configuration clears everything
        do_reset();
        check_reset_state();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule